// File: doc/BRIEF.md
# Eviction Resize and Relocation Controller

This controller sits beside a compressed main memory and handles one event: a dirty line leaves the last-level cache and comes back from the compressor with a new size class. Each page is split into subpages of a fixed number of lines. Every line owns a slot sized by its class plus a small line slack. Every subpage owns a region sized by its own class plus a subpage slack. The controller receives the page's current metadata entry together with the eviction, works out how far the size change spreads, and issues at most two move commands to an external copy engine. It then writes the updated entry back and, if the page no longer fits its class, raises an exception so software can move the whole page to a pool of another class.

While a page is being handled, the controller locks it: any access request naming that page is held off, and other pages pass freely. A line of class k holds k*16 bytes (class 0 is all zeros, class 4 is the full 64-byte line). A slot adds 8 bytes of slack. A subpage of class k may hold up to k*72+16 bytes of slots. A page of class k may hold up to k*304 bytes of subpage footprints, where a subpage's footprint is k*72+16.

Top module: `evict_resize_ctrl`

## Requirements
- R1: If the new line size is at most the old size plus the 8-byte line slack, and any shrink is no more than that slack, nothing moves and no metadata is written.
- R2: A shrink of more than the line slack issues no move. It writes the entry back with every class unchanged and bit 63 (the compaction hint) set.
- R3: A growth whose new subpage fill is within the subpage's class limit (class*72+16) gives a single move command for the later lines of that subpage. The command's source is the old end of the grown slot, its destination is the source plus the growth, and its length is the bytes of the later slots. No command is issued if the grown line is the last line of its subpage. The new class is written to the line field.
- R4: A growth beyond the subpage limit moves the subpage to the smallest class whose limit holds the new fill. If the page class still holds the new total, the controller first moves all later subpages (source is the old end of this subpage, destination is shifted by the subpage growth) and then moves the later lines as in R3. A move with zero length is skipped.
- R5: If the new page total exceeds the current page class capacity (class*304), no move is issued. The entry is written with the new line, subpage and smallest fitting page classes, and exc_valid then pulses for one cycle with the page number and the new page class.
- R6: Entry layout: line i class in bits [3i+2:3i] (i = 0..15, line i in subpage i/4); subpage j class in bits [48+3j+2:48+3j]; page class in bits [62:60]; hint in bit 63. Every write is a one-cycle pulse tagged with the page number.
- R7: page_lock rises on the cycle after an eviction is accepted and stays high for exactly 2 cycles (no change), 3 (hint only), 4 (exception), or 3 plus the cycles the moves take.
- R8: While locked, acc_ready is low for a request naming the locked page and high for any other page.
- R9: evict_ready is high only while unlocked.
- R10: After reset the controller is unlocked, ready for an eviction, and drives no move, write or exception.
- R11: A move command keeps mv_valid and its source, destination and length stable until the cycle mv_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evict_valid | input | 1 | Eviction request |
| evict_ready | output | 1 | Eviction can be accepted |
| evict_page | input | 8 | Page number of the evicted line |
| evict_line | input | 4 | Line index within the page |
| evict_cls | input | 3 | New compressed size class |
| evict_meta | input | 64 | Current metadata entry of the page |
| mv_valid | output | 1 | Move command pending |
| mv_src | output | 11 | Source byte offset in the page |
| mv_dst | output | 11 | Destination byte offset |
| mv_len | output | 11 | Byte length |
| mv_ack | input | 1 | Copy engine took the command |
| meta_wr_valid | output | 1 | Metadata write pulse |
| meta_wr_page | output | 8 | Page of the write |
| meta_wr_data | output | 64 | Updated entry |
| exc_valid | output | 1 | Page class change exception pulse |
| exc_page | output | 8 | Page needing a new pool |
| exc_class | output | 3 | Required page class |
| page_lock | output | 1 | A page is locked |
| lock_page | output | 8 | Number of the locked page |
| acc_valid | input | 1 | Access request present |
| acc_page | input | 8 | Page of the access |
| acc_ready | output | 1 | Access may proceed |

## Verification
An eviction taken on a clock edge sets page_lock from the next cycle. The first locked cycle evaluates the entry. The second locked cycle carries either the first move command, the metadata write, or the final cycle. Each move stays up until the edge that samples mv_ack. The write follows the last move by one cycle, and an exception follows the write by one cycle. The bench drives on falling edges and samples every locked cycle at the falling edge. It collects the commands, writes and exceptions it sees and counts the locked cycles against the cycle budget of R7. It runs with immediate and delayed acknowledgement and compares against an arithmetic model of the slot, subpage and page sums, sweeping every line and every new class over five page fill patterns.

// File: rtl/erc_pkg.sv
package erc_pkg;

   typedef enum logic [2:0] {
      K_KEEP  = 3'd0,
      K_NOTE  = 3'd1,
      K_LINES = 3'd2,
      K_SUBS  = 3'd3,
      K_PAGE  = 3'd4
   } erc_kind_e;

   typedef enum logic [2:0] {
      ST_IDLE          = 3'd0,
      ST_EVAL          = 3'd1,
      ST_MOVE_LINES    = 3'd2,
      ST_MOVE_SUBPAGES = 3'd3,
      ST_UPDATE_META   = 3'd4,
      ST_EXCEPTION     = 3'd5,
      ST_DONE          = 3'd6
   } erc_state_e;

endpackage

// File: rtl/erc_planner.sv
module erc_planner
   import erc_pkg::*;
#(
   parameter int NCLS       = 5,
   parameter int LINE_BYTES = 64,
   parameter int LINE_HYST  = 8,
   parameter int LPS        = 4,
   parameter int SPP        = 4,
   parameter int SUB_GRAIN  = 72,
   parameter int SUB_HYST   = 16,
   parameter int PAGE_GRAIN = 304,
   localparam int CW     = $clog2(NCLS),
   localparam int NLINES = LPS * SPP,
   localparam int IDXW   = $clog2(NLINES),
   localparam int LW     = $clog2(LPS),
   localparam int SW     = $clog2(SPP),
   localparam int GRAIN  = LINE_BYTES / (NCLS - 1),
   localparam int OFFW   = $clog2(PAGE_GRAIN * (NCLS - 1) + 1),
   localparam int META_W = (NLINES + SPP + 1) * CW + 1
)
(
   input  logic [META_W-1:0] meta_i,
   input  logic [IDXW-1:0]   line_i,
   input  logic [CW-1:0]     cls_i,
   output erc_kind_e         kind_o,
   output logic [META_W-1:0] meta_o,
   output logic              lmv_en_o,
   output logic [OFFW-1:0]   lmv_src_o,
   output logic [OFFW-1:0]   lmv_dst_o,
   output logic [OFFW-1:0]   lmv_len_o,
   output logic              smv_en_o,
   output logic [OFFW-1:0]   smv_src_o,
   output logic [OFFW-1:0]   smv_dst_o,
   output logic [OFFW-1:0]   smv_len_o
);

   localparam int SUB_LSB = NLINES * CW;
   localparam int PG_LSB  = (NLINES + SPP) * CW;

   logic [CW-1:0]   lcls [NLINES];
   logic [OFFW-1:0] slot [NLINES];
   logic [CW-1:0]   scls [SPP];
   logic [OFFW-1:0] sfp  [SPP];

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      assign lcls[g] = meta_i[g*CW +: CW];
      assign slot[g] = OFFW'(lcls[g]) * OFFW'(GRAIN) + OFFW'(LINE_HYST);
   end

   for (genvar j = 0; j < SPP; j++) begin : g_sub
      assign scls[j] = meta_i[SUB_LSB + j*CW +: CW];
      assign sfp[j]  = OFFW'(scls[j]) * OFFW'(SUB_GRAIN) + OFFW'(SUB_HYST);
   end

   function automatic logic [CW-1:0] sub_fit(input logic [OFFW-1:0] fill);
      logic [CW-1:0] r;
      r = CW'(NCLS - 1);
      for (int k = NCLS - 1; k >= 0; k--)
         if (fill <= OFFW'(k) * OFFW'(SUB_GRAIN) + OFFW'(SUB_HYST)) r = CW'(k);
      return r;
   endfunction

   function automatic logic [CW-1:0] page_fit(input logic [OFFW-1:0] fill);
      logic [CW-1:0] r;
      r = CW'(NCLS - 1);
      for (int k = NCLS - 1; k >= 0; k--)
         if (fill <= OFFW'(k) * OFFW'(PAGE_GRAIN)) r = CW'(k);
      return r;
   endfunction

   logic [SW-1:0]   sidx;
   logic [LW-1:0]   lidx;
   logic [CW-1:0]   old_c, scur, pcur, nsc;
   logic [OFFW-1:0] base, total, pre, used, oslot, osize, nsize;
   logic [OFFW-1:0] delta, newused, after_o, tail, sdelta, ssrc, newtotal;

   always_comb begin
      sidx  = line_i[IDXW-1:LW];
      lidx  = line_i[LW-1:0];
      old_c = lcls[line_i];
      oslot = slot[line_i];
      scur  = scls[sidx];
      pcur  = meta_i[PG_LSB +: CW];
      osize = OFFW'(old_c) * OFFW'(GRAIN);
      nsize = OFFW'(cls_i) * OFFW'(GRAIN);

      base  = '0;
      total = '0;
      for (int j = 0; j < SPP; j++) begin
         total = total + sfp[j];
         if (SW'(j) < sidx) base = base + sfp[j];
      end
      pre  = '0;
      used = '0;
      for (int g = 0; g < NLINES; g++) begin
         if (SW'(g / LPS) == sidx) begin
            used = used + slot[g];
            if (LW'(g % LPS) < lidx) pre = pre + slot[g];
         end
      end

      delta    = nsize - osize;
      newused  = used + delta;
      after_o  = base + pre + oslot;
      tail     = used - pre - oslot;
      nsc      = sub_fit(newused);
      sdelta   = (OFFW'(nsc) - OFFW'(scur)) * OFFW'(SUB_GRAIN);
      ssrc     = base + sfp[sidx];
      newtotal = total + sdelta;

      kind_o    = K_KEEP;
      meta_o    = meta_i;
      lmv_en_o  = 1'b0;
      lmv_src_o = after_o;
      lmv_dst_o = after_o + delta;
      lmv_len_o = tail;
      smv_en_o  = 1'b0;
      smv_src_o = ssrc;
      smv_dst_o = ssrc + sdelta;
      smv_len_o = total - ssrc;

      if (nsize <= osize + OFFW'(LINE_HYST)) begin
         if (nsize + OFFW'(LINE_HYST) < osize) begin
            kind_o            = K_NOTE;
            meta_o[META_W-1]  = 1'b1;
         end
      end else begin
         meta_o[line_i*CW +: CW] = cls_i;
         if (newused <= OFFW'(scur) * OFFW'(SUB_GRAIN) + OFFW'(SUB_HYST)) begin
            kind_o   = K_LINES;
            lmv_en_o = (tail != '0);
         end else begin
            meta_o[SUB_LSB + sidx*CW +: CW] = nsc;
            if (newtotal <= OFFW'(pcur) * OFFW'(PAGE_GRAIN)) begin
               kind_o   = K_SUBS;
               lmv_en_o = (tail != '0);
               smv_en_o = (total != ssrc);
            end else begin
               kind_o                  = K_PAGE;
               meta_o[PG_LSB +: CW]    = page_fit(newtotal);
            end
         end
      end
   end

endmodule

// File: rtl/erc_page_gate.sv
module erc_page_gate #(
   parameter int PAGE_W = 8
)
(
   input  logic              lock_i,
   input  logic [PAGE_W-1:0] lock_page_i,
   input  logic              acc_valid_i,
   input  logic [PAGE_W-1:0] acc_page_i,
   output logic              acc_ready_o
);

   logic hit;

   always_comb begin
      hit         = acc_valid_i && (acc_page_i == lock_page_i);
      acc_ready_o = !(lock_i && hit);
   end

endmodule

// File: rtl/evict_resize_ctrl.sv
module evict_resize_ctrl
   import erc_pkg::*;
#(
   parameter int NCLS       = 5,
   parameter int LINE_BYTES = 64,
   parameter int LINE_HYST  = 8,
   parameter int LPS        = 4,
   parameter int SPP        = 4,
   parameter int SUB_GRAIN  = 72,
   parameter int SUB_HYST   = 16,
   parameter int PAGE_GRAIN = 304,
   parameter int PAGE_W     = 8,
   localparam int CW     = $clog2(NCLS),
   localparam int NLINES = LPS * SPP,
   localparam int IDXW   = $clog2(NLINES),
   localparam int OFFW   = $clog2(PAGE_GRAIN * (NCLS - 1) + 1),
   localparam int META_W = (NLINES + SPP + 1) * CW + 1
)
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evict_valid,
   output logic              evict_ready,
   input  logic [PAGE_W-1:0] evict_page,
   input  logic [IDXW-1:0]   evict_line,
   input  logic [CW-1:0]     evict_cls,
   input  logic [META_W-1:0] evict_meta,
   output logic              mv_valid,
   output logic [OFFW-1:0]   mv_src,
   output logic [OFFW-1:0]   mv_dst,
   output logic [OFFW-1:0]   mv_len,
   input  logic              mv_ack,
   output logic              meta_wr_valid,
   output logic [PAGE_W-1:0] meta_wr_page,
   output logic [META_W-1:0] meta_wr_data,
   output logic              exc_valid,
   output logic [PAGE_W-1:0] exc_page,
   output logic [CW-1:0]     exc_class,
   output logic              page_lock,
   output logic [PAGE_W-1:0] lock_page,
   input  logic              acc_valid,
   input  logic [PAGE_W-1:0] acc_page,
   output logic              acc_ready
);

   localparam int PG_LSB = (NLINES + SPP) * CW;

   if (NCLS < 3 || (LINE_BYTES % (NCLS - 1)) != 0) begin : g_bad_cls
      $error("class count must be at least 3 and divide the line size evenly");
   end
   if (LPS < 2 || (LPS & (LPS - 1)) != 0 || SPP < 2 || (SPP & (SPP - 1)) != 0) begin : g_bad_geo
      $error("lines per subpage and subpages per page must be powers of two of at least 2");
   end
   if (SUB_GRAIN * (NCLS - 1) + SUB_HYST < LPS * (LINE_BYTES + LINE_HYST)) begin : g_bad_sub
      $error("largest subpage class cannot hold a full subpage");
   end
   if (PAGE_GRAIN * (NCLS - 1) < SPP * (SUB_GRAIN * (NCLS - 1) + SUB_HYST)) begin : g_bad_page
      $error("largest page class cannot hold a full page");
   end

   erc_state_e        state;
   logic [PAGE_W-1:0] req_page;
   logic [IDXW-1:0]   req_line;
   logic [CW-1:0]     req_cls;
   logic [META_W-1:0] req_meta;

   erc_kind_e         p_kind, kind_q;
   logic [META_W-1:0] p_meta, meta_q;
   logic              p_len, p_sen, lmv_en_q, smv_en_q;
   logic [OFFW-1:0]   p_lsrc, p_ldst, p_llen, p_ssrc, p_sdst, p_slen;
   logic [OFFW-1:0]   lsrc_q, ldst_q, llen_q, ssrc_q, sdst_q, slen_q;

   erc_planner #(
      .NCLS(NCLS), .LINE_BYTES(LINE_BYTES), .LINE_HYST(LINE_HYST),
      .LPS(LPS), .SPP(SPP), .SUB_GRAIN(SUB_GRAIN), .SUB_HYST(SUB_HYST),
      .PAGE_GRAIN(PAGE_GRAIN)
   ) u_plan (
      .meta_i(req_meta), .line_i(req_line), .cls_i(req_cls),
      .kind_o(p_kind), .meta_o(p_meta),
      .lmv_en_o(p_len), .lmv_src_o(p_lsrc), .lmv_dst_o(p_ldst), .lmv_len_o(p_llen),
      .smv_en_o(p_sen), .smv_src_o(p_ssrc), .smv_dst_o(p_sdst), .smv_len_o(p_slen)
   );

   erc_page_gate #(.PAGE_W(PAGE_W)) u_gate (
      .lock_i(page_lock), .lock_page_i(req_page),
      .acc_valid_i(acc_valid), .acc_page_i(acc_page), .acc_ready_o(acc_ready)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         req_page <= '0;
         req_line <= '0;
         req_cls  <= '0;
         req_meta <= '0;
         kind_q   <= K_KEEP;
         meta_q   <= '0;
         lmv_en_q <= 1'b0;
         smv_en_q <= 1'b0;
         lsrc_q   <= '0;
         ldst_q   <= '0;
         llen_q   <= '0;
         ssrc_q   <= '0;
         sdst_q   <= '0;
         slen_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (evict_valid) begin
                  req_page <= evict_page;
                  req_line <= evict_line;
                  req_cls  <= evict_cls;
                  req_meta <= evict_meta;
                  state    <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               kind_q   <= p_kind;
               meta_q   <= p_meta;
               lmv_en_q <= p_len;
               smv_en_q <= p_sen;
               lsrc_q   <= p_lsrc;
               ldst_q   <= p_ldst;
               llen_q   <= p_llen;
               ssrc_q   <= p_ssrc;
               sdst_q   <= p_sdst;
               slen_q   <= p_slen;
               case (p_kind)
                  K_KEEP:  state <= ST_DONE;
                  K_LINES: state <= p_len ? ST_MOVE_LINES : ST_UPDATE_META;
                  K_SUBS:  state <= p_sen ? ST_MOVE_SUBPAGES
                                          : (p_len ? ST_MOVE_LINES : ST_UPDATE_META);
                  default: state <= ST_UPDATE_META;
               endcase
            end
            ST_MOVE_SUBPAGES: begin
               if (mv_ack) state <= lmv_en_q ? ST_MOVE_LINES : ST_UPDATE_META;
            end
            ST_MOVE_LINES: begin
               if (mv_ack) state <= ST_UPDATE_META;
            end
            ST_UPDATE_META: state <= (kind_q == K_PAGE) ? ST_EXCEPTION : ST_DONE;
            ST_EXCEPTION:   state <= ST_DONE;
            default:        state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      evict_ready   = (state == ST_IDLE);
      page_lock     = (state != ST_IDLE);
      lock_page     = req_page;
      mv_valid      = (state == ST_MOVE_LINES) || (state == ST_MOVE_SUBPAGES);
      mv_src        = (state == ST_MOVE_SUBPAGES) ? ssrc_q : lsrc_q;
      mv_dst        = (state == ST_MOVE_SUBPAGES) ? sdst_q : ldst_q;
      mv_len        = (state == ST_MOVE_SUBPAGES) ? slen_q : llen_q;
      meta_wr_valid = (state == ST_UPDATE_META);
      meta_wr_page  = req_page;
      meta_wr_data  = meta_q;
      exc_valid     = (state == ST_EXCEPTION);
      exc_page      = req_page;
      exc_class     = meta_q[PG_LSB +: CW];
   end

   // R11
   mv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mv_valid && !mv_ack) |=> (mv_valid && $stable(mv_src) && $stable(mv_dst) && $stable(mv_len)));

   // R8
   gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (page_lock && acc_valid && acc_page == lock_page) |-> !acc_ready);

   // R7
   lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evict_valid && evict_ready) |=> page_lock);

   // R5
   exc_after_meta_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> $past(meta_wr_valid));

   // R6
   meta_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      meta_wr_valid |=> !meta_wr_valid);

   // R9
   ready_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evict_ready |-> !mv_valid && !meta_wr_valid && !exc_valid);

endmodule

// File: tb/evict_resize_ctrl_test.sv
`timescale 1ns/1ps
module evict_resize_ctrl_test;

   localparam int MW = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evict_valid = 1'b0;
   logic        evict_ready;
   logic [7:0]  evict_page = '0;
   logic [3:0]  evict_line = '0;
   logic [2:0]  evict_cls = '0;
   logic [63:0] evict_meta = '0;
   logic        mv_valid;
   logic [10:0] mv_src, mv_dst, mv_len;
   logic        mv_ack = 1'b0;
   logic        meta_wr_valid;
   logic [7:0]  meta_wr_page;
   logic [63:0] meta_wr_data;
   logic        exc_valid;
   logic [7:0]  exc_page;
   logic [2:0]  exc_class;
   logic        page_lock;
   logic [7:0]  lock_page;
   logic        acc_valid = 1'b0;
   logic [7:0]  acc_page = '0;
   logic        acc_ready;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   evict_resize_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .evict_valid(evict_valid), .evict_ready(evict_ready),
      .evict_page(evict_page), .evict_line(evict_line), .evict_cls(evict_cls),
      .evict_meta(evict_meta),
      .mv_valid(mv_valid), .mv_src(mv_src), .mv_dst(mv_dst), .mv_len(mv_len),
      .mv_ack(mv_ack),
      .meta_wr_valid(meta_wr_valid), .meta_wr_page(meta_wr_page), .meta_wr_data(meta_wr_data),
      .exc_valid(exc_valid), .exc_page(exc_page), .exc_class(exc_class),
      .page_lock(page_lock), .lock_page(lock_page),
      .acc_valid(acc_valid), .acc_page(acc_page), .acc_ready(acc_ready)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic int subfit(input int u);
      for (int k = 0; k < 5; k++) if (u <= k * 72 + 16) return k;
      return 4;
   endfunction

   function automatic int pagefit(input int u);
      for (int k = 0; k < 5; k++) if (u <= k * 304) return k;
      return 4;
   endfunction

   function automatic int pat_cls(input int p, input int i);
      case (p)
         0: return 1;
         1: return 2;
         2: return (i < 12) ? 3 : 2;
         3: return (i * 3 + 1) % 5;
         default: return 0;
      endcase
   endfunction

   function automatic logic [63:0] build(input int p);
      logic [63:0] m;
      int tot;
      m = '0;
      tot = 0;
      for (int i = 0; i < 16; i++) m[i*3 +: 3] = 3'(pat_cls(p, i));
      for (int j = 0; j < 4; j++) begin
         int u, sc;
         u = 0;
         for (int l = 0; l < 4; l++) u += int'(m[(j*4+l)*3 +: 3]) * 16 + 8;
         sc = subfit(u);
         m[48 + j*3 +: 3] = 3'(sc);
         tot += sc * 72 + 16;
      end
      m[60 +: 3] = 3'(pagefit(tot));
      return m;
   endfunction

   // kind: 0 keep (R1), 1 hint (R2), 2 lines (R3), 3 subpages (R4), 4 page class (R5)
   task automatic model(input logic [63:0] m, input int idx, input int nc,
                        output int kind, output logic [63:0] mo, output int nmv,
                        output logic [32:0] mv0, output logic [32:0] mv1);
      int s, l, base, total, pre, used, oc, osz, nsz, delta, nu, aft, tail, sc, pc;
      logic [32:0] mvs [2];
      s = idx / 4; l = idx % 4;
      base = 0; total = 0; pre = 0; used = 0;
      for (int j = 0; j < 4; j++) begin
         int f;
         f = int'(m[48 + j*3 +: 3]) * 72 + 16;
         total += f;
         if (j < s) base += f;
      end
      for (int k = 0; k < 4; k++) begin
         int sl;
         sl = int'(m[(s*4+k)*3 +: 3]) * 16 + 8;
         used += sl;
         if (k < l) pre += sl;
      end
      oc = int'(m[idx*3 +: 3]);
      sc = int'(m[48 + s*3 +: 3]);
      pc = int'(m[60 +: 3]);
      osz = oc * 16; nsz = nc * 16;
      mo = m; nmv = 0; kind = 0;
      mvs[0] = '0; mvs[1] = '0;
      if (nsz <= osz + 8) begin
         if (osz - nsz > 8) begin kind = 1; mo[63] = 1'b1; end
      end else begin
         delta = nsz - osz;
         mo[idx*3 +: 3] = 3'(nc);
         nu = used + delta;
         aft = base + pre + osz + 8;
         tail = used - pre - (osz + 8);
         if (nu <= sc * 72 + 16) begin
            kind = 2;
            if (tail > 0) begin mvs[nmv] = {11'(aft), 11'(aft + delta), 11'(tail)}; nmv++; end
         end else begin
            int nsc, sd, ssrc, nt;
            nsc = subfit(nu);
            sd = (nsc - sc) * 72;
            mo[48 + s*3 +: 3] = 3'(nsc);
            ssrc = base + sc * 72 + 16;
            nt = total + sd;
            if (nt <= pc * 304) begin
               kind = 3;
               if (total > ssrc) begin mvs[nmv] = {11'(ssrc), 11'(ssrc + sd), 11'(total - ssrc)}; nmv++; end
               if (tail > 0) begin mvs[nmv] = {11'(aft), 11'(aft + delta), 11'(tail)}; nmv++; end
            end else begin
               kind = 4;
               mo[60 +: 3] = 3'(pagefit(nt));
            end
         end
      end
      mv0 = mvs[0]; mv1 = mvs[1];
   endtask

   task automatic run_case(input logic [63:0] m, input int idx, input int nc,
                           input logic [7:0] pg, input int hold, input bit other);
      int kind, nmv, exp_lock, lock_cnt, got_mv, wait_c, got_meta, got_exc;
      logic [63:0] mo, meta_seen;
      logic [32:0] e0, e1, last;
      logic [32:0] seen [2];
      logic [7:0] page_seen, epage_seen;
      logic [2:0] ecls_seen;
      bit blk_bad, rdy_bad, hold_bad;
      string tg;
      model(m, idx, nc, kind, mo, nmv, e0, e1);
      case (kind)
         0: tg = "R1";
         1: tg = "R2";
         2: tg = "R3";
         3: tg = "R4";
         default: tg = "R5";
      endcase
      case (kind)
         0: exp_lock = 2;
         1: exp_lock = 3;
         4: exp_lock = 4;
         default: exp_lock = 3 + nmv * (hold + 1);
      endcase
      @(negedge clk);
      evict_valid = 1'b1; evict_page = pg; evict_line = 4'(idx);
      evict_cls = 3'(nc); evict_meta = m;
      acc_valid = 1'b1; acc_page = other ? pg + 8'd1 : pg;
      @(negedge clk);
      evict_valid = 1'b0;
      lock_cnt = 0; got_mv = 0; wait_c = 0; got_meta = 0; got_exc = 0;
      blk_bad = 0; rdy_bad = 0; hold_bad = 0;
      seen[0] = '0; seen[1] = '0; last = '0;
      meta_seen = '0; page_seen = '0; epage_seen = '0; ecls_seen = '0;
      for (int c = 0; c < 40; c++) begin
         if (!page_lock) break;
         lock_cnt++;
         if (acc_ready !== other) blk_bad = 1;
         if (evict_ready) rdy_bad = 1;
         if (meta_wr_valid) begin got_meta++; meta_seen = meta_wr_data; page_seen = meta_wr_page; end
         if (exc_valid) begin got_exc++; epage_seen = exc_page; ecls_seen = exc_class; end
         if (mv_valid) begin
            if (wait_c == 0) begin
               last = {mv_src, mv_dst, mv_len};
               if (got_mv < 2) seen[got_mv] = last;
               got_mv++;
            end else if ({mv_src, mv_dst, mv_len} !== last) hold_bad = 1;
            if (wait_c >= hold) begin mv_ack = 1'b1; wait_c = 0; end
            else begin mv_ack = 1'b0; wait_c++; end
         end else begin
            mv_ack = 1'b0;
         end
         @(negedge clk);
      end
      mv_ack = 1'b0;
      chk("R7", "locked cycles", 64'(lock_cnt), 64'(exp_lock));
      chk("R8", "access gate during lock", 64'(blk_bad), 64'd0);
      chk("R8", "access after unlock", 64'(acc_ready), 64'd1);
      chk("R9", "evict_ready while locked", 64'(rdy_bad), 64'd0);
      chk(tg, "move count", 64'(got_mv), 64'(nmv));
      if (nmv > 0) chk(tg, "first move", 64'(seen[0]), 64'(e0));
      if (nmv > 1) chk(tg, "second move", 64'(seen[1]), 64'(e1));
      if (hold > 0 && nmv > 0) chk("R11", "move held stable", 64'(hold_bad), 64'd0);
      chk(tg, "metadata writes", 64'(got_meta), (kind == 0) ? 64'd0 : 64'd1);
      if (kind != 0) begin
         chk("R6", "metadata entry", meta_seen, mo);
         chk("R6", "metadata page", 64'(page_seen), 64'(pg));
      end
      chk("R5", "exceptions", 64'(got_exc), (kind == 4) ? 64'd1 : 64'd0);
      if (kind == 4) begin
         chk("R5", "exception class", 64'(ecls_seen), 64'(mo[60 +: 3]));
         chk("R5", "exception page", 64'(epage_seen), 64'(pg));
      end
      acc_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "evict_ready", 64'(evict_ready), 64'd1);
      chk("R10", "page_lock", 64'(page_lock), 64'd0);
      chk("R10", "outputs idle", 64'({mv_valid, meta_wr_valid, exc_valid}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "idle after release", 64'({evict_ready, page_lock}), 64'b10);
      for (int p = 0; p < 5; p++) begin
         logic [63:0] m;
         m = build(p);
         for (int idx = 0; idx < 16; idx++)
            for (int nc = 0; nc < 5; nc++)
               run_case(m, idx, nc, 8'(p * 16 + idx), (p == 1 || p == 3) ? 2 : 0,
                        (p == 4 && nc == 2));
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule